// File: doc/BRIEF.md
# FPU Opcode Capture Registers

This block watches the instruction stream of a floating-point unit and keeps three 11-bit opcode snapshots:
- the instruction most recently prefetched;
- the most recent non-control instruction executed;
- the most recent non-control instruction that faulted.

Every snapshot uses one packed form. The top three bits are the low three bits of the first opcode byte. The low eight bits are the second opcode byte.

A two-bit register port gives software read access to all three snapshots. Only the fault snapshot accepts writes. An environment-store strobe copies the fault snapshot into a registered image output. An environment-load strobe restores the fault snapshot from an incoming image field. Together these let the opcode field of a saved environment round-trip through the block. The block does no floating-point arithmetic and handles no exceptions. It only records what it is shown.

Top module: `fpu_opcode_capture`

## Requirements
- R1: After reset all three snapshots read 0 and `env_store_op` is 0.
- R2: On a clock edge with `pf_valid` high, the prefetch snapshot becomes `{pf_byte0[2:0], pf_byte1}`, unless R3 applies.
- R3: A prefetched instruction whose first byte is 0x9B (the wait instruction) is recorded as 0x09B, whatever `pf_byte1` holds.
- R4: On an edge with `ex_valid` high and `ex_ctrl` low, the executed snapshot becomes `{ex_lo3, ex_byte1}`. With `ex_ctrl` high it keeps its value.
- R5: On an edge with `ex_valid` and `ex_fault` high and `ex_ctrl` low, the fault snapshot becomes `{ex_lo3, ex_byte1}`. A faulting control instruction and a non-faulting instruction leave it unchanged.
- R6: `reg_rdata` shows the selected value in the same cycle: `reg_sel` 0 gives prefetch, 1 gives executed, 2 gives fault, and 3 reads 0.
- R7: A write (`reg_wr` high) with `reg_sel` 2 loads `reg_wdata` into the fault snapshot at the edge. Writes with `reg_sel` 0, 1 or 3 change nothing.
- R8: On an edge with `env_store` high, `env_store_op` loads the fault snapshot value held before that edge. Otherwise `env_store_op` holds its value.
- R9: On an edge with `env_load` high, the fault snapshot loads `env_load_op`.
- R10: When more than one source updates the fault snapshot in one cycle, the hardware fault capture wins over an environment load, and an environment load wins over a port write.
- R11: The prefetch and executed snapshots update independently. A prefetch never changes the executed snapshot, and an execution never changes the prefetch snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_valid | input | 1 | A floating-point instruction was prefetched |
| pf_byte0 | input | 8 | First opcode byte of the prefetched instruction |
| pf_byte1 | input | 8 | Second opcode byte of the prefetched instruction |
| ex_valid | input | 1 | An instruction completed execution |
| ex_lo3 | input | 3 | Low three bits of the executed first opcode byte |
| ex_byte1 | input | 8 | Second opcode byte of the executed instruction |
| ex_ctrl | input | 1 | Executed instruction is a control instruction |
| ex_fault | input | 1 | Executed instruction raised an exception |
| reg_sel | input | 2 | Register port select |
| reg_wr | input | 1 | Register port write strobe |
| reg_wdata | input | 11 | Register port write data |
| reg_rdata | output | 11 | Register port read data |
| env_store | input | 1 | Environment store strobe |
| env_store_op | output | 11 | Opcode field of the stored environment image |
| env_load | input | 1 | Environment load strobe |
| env_load_op | input | 11 | Opcode field of the environment image being loaded |

## Verification
The assertions assume the strobes are sampled only on the clock edge. They also assume `ex_fault` has meaning only while `ex_valid` is high. Because of this, a fault-capture property refers to `ex_valid` and `ex_ctrl` together with `ex_fault`, and never to `ex_fault` alone.

The bench drives every input on the falling edge and clears all strobes after each cycle. It raises `ex_fault` only together with `ex_valid`. Collisions between sources on the fault snapshot are created on purpose, one pair at a time, so that each priority rule is seen on its own.

// File: rtl/fpu_opcode_capture.sv
`timescale 1ns/1ps
module fpu_opcode_capture #(
  parameter int BYTE_W = 8,
  parameter int HI_W = 3,
  parameter logic [BYTE_W-1:0] WAIT_BYTE = 8'h9B
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pf_valid,
  input  logic [BYTE_W-1:0]      pf_byte0,
  input  logic [BYTE_W-1:0]      pf_byte1,
  input  logic                   ex_valid,
  input  logic [HI_W-1:0]        ex_lo3,
  input  logic [BYTE_W-1:0]      ex_byte1,
  input  logic                   ex_ctrl,
  input  logic                   ex_fault,
  input  logic [1:0]             reg_sel,
  input  logic                   reg_wr,
  input  logic [HI_W+BYTE_W-1:0] reg_wdata,
  output logic [HI_W+BYTE_W-1:0] reg_rdata,
  input  logic                   env_store,
  output logic [HI_W+BYTE_W-1:0] env_store_op,
  input  logic                   env_load,
  input  logic [HI_W+BYTE_W-1:0] env_load_op
);
  localparam int OP_W = HI_W + BYTE_W;
  localparam logic [1:0] SEL_PF  = 2'd0;
  localparam logic [1:0] SEL_EX  = 2'd1;
  localparam logic [1:0] SEL_EXC = 2'd2;
  localparam logic [OP_W-1:0] WAIT_CODE = {{HI_W{1'b0}}, WAIT_BYTE};

  logic [OP_W-1:0] pf_q, ex_q, exc_q;
  logic [OP_W-1:0] pf_enc, ex_enc;
  logic            ex_take, exc_cap, exc_wr;

  assign pf_enc  = (pf_byte0 == WAIT_BYTE) ? WAIT_CODE : {pf_byte0[HI_W-1:0], pf_byte1};
  assign ex_enc  = {ex_lo3, ex_byte1};
  assign ex_take = ex_valid && !ex_ctrl;
  assign exc_cap = ex_take && ex_fault;
  assign exc_wr  = reg_wr && (reg_sel == SEL_EXC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_q <= '0;
      ex_q <= '0;
    end else begin
      if (pf_valid) pf_q <= pf_enc;
      if (ex_take)  ex_q <= ex_enc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        exc_q <= '0;
    else if (exc_cap)  exc_q <= ex_enc;
    else if (env_load) exc_q <= env_load_op;
    else if (exc_wr)   exc_q <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         env_store_op <= '0;
    else if (env_store) env_store_op <= exc_q;
  end

  always_comb begin
    case (reg_sel)
      SEL_PF:  reg_rdata = pf_q;
      SEL_EX:  reg_rdata = ex_q;
      SEL_EXC: reg_rdata = exc_q;
      default: reg_rdata = '0;
    endcase
  end

  AST_WAIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_byte0 == WAIT_BYTE) |=> (pf_q == WAIT_CODE)); // R3
  AST_CTRL_KEEPS_EX: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_ctrl) |=> $stable(ex_q)); // R4
  AST_CTRL_KEEPS_PF: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_valid |=> $stable(pf_q)); // R11
  AST_EXC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ex_valid && ex_fault) && !env_load && !reg_wr) |=> $stable(exc_q)); // R5
  AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && !ex_ctrl && ex_fault && (env_load || reg_wr))
      |=> (exc_q == {$past(ex_lo3), $past(ex_byte1)})); // R10
  AST_STORE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    env_store |=> (env_store_op == $past(exc_q))); // R8
  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !env_store |=> $stable(env_store_op)); // R8
  AST_SEL3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd3) |-> (reg_rdata == '0)); // R6
endmodule

// File: tb/tb_fpu_opcode_capture.sv
`timescale 1ns/1ps
module tb_fpu_opcode_capture;
  logic clk = 1'b0;
  logic rst_n;
  logic pf_valid, ex_valid, ex_ctrl, ex_fault, reg_wr, env_store, env_load;
  logic [7:0] pf_byte0, pf_byte1, ex_byte1;
  logic [2:0] ex_lo3;
  logic [1:0] reg_sel;
  logic [10:0] reg_wdata, reg_rdata, env_store_op, env_load_op;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fpu_opcode_capture dut (
    .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_byte0(pf_byte0), .pf_byte1(pf_byte1),
    .ex_valid(ex_valid), .ex_lo3(ex_lo3), .ex_byte1(ex_byte1), .ex_ctrl(ex_ctrl), .ex_fault(ex_fault),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .env_store(env_store), .env_store_op(env_store_op), .env_load(env_load), .env_load_op(env_load_op));

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic idle();
    pf_valid = 0; ex_valid = 0; ex_ctrl = 0; ex_fault = 0; reg_wr = 0;
    env_store = 0; env_load = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [1:0] sel, output logic [10:0] v);
    reg_sel = sel;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic prefetch(input logic [7:0] b0, input logic [7:0] b1);
    pf_valid = 1; pf_byte0 = b0; pf_byte1 = b1;
    tick();
  endtask

  task automatic execute(input logic [2:0] lo, input logic [7:0] b1, input logic c, input logic f);
    ex_valid = 1; ex_lo3 = lo; ex_byte1 = b1; ex_ctrl = c; ex_fault = f;
    tick();
  endtask

  task automatic t_reset();
    logic [10:0] v;
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], v);
      check("R1 reset read", v, 11'h000);
    end
    check("R1 reset store image", env_store_op, 11'h000);
  endtask

  task automatic t_prefetch();
    logic [10:0] v;
    prefetch(8'hD9, 8'hE8);
    rd(0, v); check("R2 prefetch D9 E8", v, 11'h1E8);
    rd(1, v); check("R11 exec untouched by prefetch", v, 11'h000);
    prefetch(8'h9B, 8'h55);
    rd(0, v); check("R3 wait recorded", v, 11'h09B);
  endtask

  task automatic t_execute();
    logic [10:0] v;
    execute(3'h6, 8'hC1, 0, 0);
    rd(1, v); check("R4 exec DE C1", v, 11'h6C1);
    rd(0, v); check("R11 prefetch untouched by exec", v, 11'h09B);
    execute(3'h1, 8'h30, 1, 0);
    rd(1, v); check("R4 control keeps exec", v, 11'h6C1);
  endtask

  task automatic t_fault();
    logic [10:0] v;
    execute(3'h4, 8'hF8, 0, 1);
    rd(2, v); check("R5 fault captured", v, 11'h4F8);
    rd(1, v); check("R4 faulting exec recorded", v, 11'h4F8);
    execute(3'h1, 8'h20, 1, 1);
    rd(2, v); check("R5 control fault ignored", v, 11'h4F8);
    execute(3'h0, 8'hC1, 0, 0);
    rd(2, v); check("R5 clean exec keeps fault", v, 11'h4F8);
    rd(1, v); check("R4 clean exec recorded", v, 11'h0C1);
  endtask

  task automatic t_regs();
    logic [10:0] v;
    for (int s = 0; s < 4; s++) begin
      if (s != 2) begin
        reg_sel = s[1:0]; reg_wr = 1; reg_wdata = 11'h7FF;
        tick();
      end
    end
    rd(0, v); check("R7 prefetch read-only", v, 11'h09B);
    rd(1, v); check("R7 exec read-only", v, 11'h0C1);
    rd(2, v); check("R7 fault unaffected by other writes", v, 11'h4F8);
    rd(3, v); check("R6 select 3 reads zero", v, 11'h000);
    reg_sel = 2; reg_wr = 1; reg_wdata = 11'h123;
    tick();
    rd(2, v); check("R7 fault write", v, 11'h123);
  endtask

  task automatic t_store();
    env_store = 1;
    tick();
    check("R8 store image", env_store_op, 11'h123);
    reg_sel = 2; reg_wr = 1; reg_wdata = 11'h2AA;
    tick();
    check("R8 image holds without strobe", env_store_op, 11'h123);
    env_store = 1;
    tick();
    check("R8 written value in next store", env_store_op, 11'h2AA);
  endtask

  task automatic t_load();
    logic [10:0] v;
    env_load = 1; env_load_op = 11'h155;
    tick();
    rd(2, v); check("R9 env load", v, 11'h155);
  endtask

  task automatic t_prio();
    logic [10:0] v;
    reg_sel = 2; reg_wr = 1; reg_wdata = 11'h001;
    ex_valid = 1; ex_lo3 = 3'h5; ex_byte1 = 8'hD8; ex_fault = 1; ex_ctrl = 0;
    tick();
    rd(2, v); check("R10 capture beats write", v, 11'h5D8);
    reg_sel = 2; reg_wr = 1; reg_wdata = 11'h011;
    env_load = 1; env_load_op = 11'h0AA;
    tick();
    rd(2, v); check("R10 load beats write", v, 11'h0AA);
    env_load = 1; env_load_op = 11'h777;
    ex_valid = 1; ex_lo3 = 3'h2; ex_byte1 = 8'h3C; ex_fault = 1; ex_ctrl = 0;
    tick();
    rd(2, v); check("R10 capture beats load", v, 11'h23C);
  endtask

  initial begin
    idle();
    rst_n = 0; pf_byte0 = 0; pf_byte1 = 0; ex_lo3 = 0; ex_byte1 = 0;
    reg_sel = 0; reg_wdata = 0; env_load_op = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_prefetch();
    t_execute();
    t_fault();
    t_regs();
    t_store();
    t_load();
    t_prio();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule